// File: doc/BRIEF.md
# Indirect Configuration-Space Access Bridge

This block sits on the host side of a local peripheral bus and turns the CPU's plain I/O-port reads and writes into geographic configuration-space cycles. Software first stores a complete target description (enable bit, bus, slot, function and doubleword index) through a 32-bit write to the address port at 0xCF8. It then accesses the data port at 0xCFC-0xCFF. The bridge turns each data-port access into one configuration read or write. That cycle raises a select line wired to the addressed slot only and presents a configuration command code, the function number, the doubleword-aligned register offset, the byte lanes and the write data.

The bridge does not wait on an empty slot forever. If the selected device does not acknowledge within a fixed number of clocks, the bridge ends the cycle itself. A read then returns all ones, which is the value enumeration software takes to mean "nothing here". Targets on another bus number, or beyond the number of wired slots, get the same all-ones answer and no select line is raised. Accesses the bridge does not claim are flagged for ordinary I/O handling. This covers the data port while the enable bit is clear, partial-width writes to the address port, and any other address.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register reads back as zero, no select line is high, the command output is 0x0 (idle), and io_ack and io_pass are low. A reset in the middle of a cycle drops the select line and command at once.
- R2: A read or write strobe at the address port with all four byte enables set completes with io_ack in the cycle after the strobe. A write loads bit 31 (enable), bits 23:16 (bus), 15:11 (slot), 10:8 (function) and 7:2 (doubleword). A read returns those fields with bits 30:24 and 1:0 as zero.
- R3: A strobe to the address port with fewer than four byte enables, or to any address outside both ports, gives io_pass in the next cycle. It does not give io_ack, leaves the address register unchanged and raises no select line.
- R4: While the enable bit (bit 31) is clear, a data-port access gives io_pass in the next cycle and starts no configuration cycle.
- R5: While the enable bit is set and the target is present, a data-port access raises exactly the select bit whose index is the slot number, from the edge that samples the strobe. That edge also drives command 0xA for a read or 0xB for a write, the function number, offset {doubleword, 2'b00}, the byte enables and the write data. All of these stay stable until the cycle ends.
- R6: A device acknowledgement sampled on the k-th edge after the cycle began (k counted from 1, k up to the timeout) ends the cycle on that edge. io_ack is high in the following cycle, carrying the device read data for a read. The select line and command drop on the same edge.
- R7: With no acknowledgement, the cycle ends on the TIMEOUT-th edge after it began (default 8). io_ack then carries 0xFFFFFFFF for a read. No select line stays high for more than TIMEOUT cycles.
- R8: A target with a nonzero bus number or a slot number of NUM_SLOTS or more raises no select line and keeps the command idle. The bridge ignores cfg_ack and answers after TIMEOUT edges with 0xFFFFFFFF.
- R9: Strobes that arrive while a configuration cycle is in progress have no effect. They produce neither io_ack nor io_pass and do not change the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | CPU I/O byte address |
| io_be | input | 4 | CPU byte enables |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 32 | CPU write data |
| io_rdata | output | 32 | Read data, valid while io_ack is high |
| io_ack | output | 1 | Access claimed and completed by the bridge |
| io_pass | output | 1 | Access not claimed; handle as ordinary I/O |
| cfg_sel | output | NUM_SLOTS | One select line per slot |
| cfg_cmd | output | 4 | Cycle command code (0xA read, 0xB write, 0x0 idle) |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 8 | Register byte offset, doubleword aligned |
| cfg_be | output | 4 | Byte lanes of the configuration access |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Read data from the selected device |
| cfg_ack | input | 1 | Device acknowledgement |

## Verification
The hardest cases involve a cycle that is already running. The first is an acknowledgement that arrives on the same edge the timeout counter expires, where the device data must win. The bench reaches it by holding the device model's reply back exactly TIMEOUT-1 cycles after the select rises. The second is a strobe issued while a cycle is running. The bench reaches it by starting a data read to a silent slot and pushing an address-port write in the middle of the wait. It then reads the register back after the timeout to show that the write was dropped.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam logic [3:0] CMD_IDLE   = 4'h0;
  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] dword;
  } tgt_addr_t;

  typedef enum logic {ST_IDLE, ST_WAIT} eng_st_t;

  function automatic logic [31:0] pack_tgt(input tgt_addr_t a);
    return {a.en, 7'b0, a.bus, a.dev, a.func, a.dword, 2'b00};
  endfunction
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] wdata,
  output tgt_addr_t   tgt,
  output logic [31:0] rd_word
);
  logic unused_addr_bits;
  assign unused_addr_bits = ^{wdata[30:24], wdata[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt <= '0;
    end else if (load) begin
      tgt.en    <= wdata[31];
      tgt.bus   <= wdata[23:16];
      tgt.dev   <= wdata[15:11];
      tgt.func  <= wdata[10:8];
      tgt.dword <= wdata[7:2];
    end
  end

  assign rd_word = pack_tgt(tgt);
endmodule

// File: rtl/cfgb_slot_decode.sv
module cfgb_slot_decode #(
  parameter int NUM_SLOTS = 8
) (
  input  logic [7:0]           bus,
  input  logic [4:0]           dev,
  output logic                 present,
  output logic [NUM_SLOTS-1:0] onehot
);
  localparam int DEV_LIMIT = (NUM_SLOTS > 32) ? 32 : NUM_SLOTS;

  assign present = (bus == 8'h00) && (int'(dev) < DEV_LIMIT);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
    assign onehot[g] = present && (dev == 5'(g));
  end
endmodule

// File: rtl/cfgb_cycle_eng.sv
module cfgb_cycle_eng
  import cfgb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int TIMEOUT   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 is_wr,
  input  logic                 present,
  input  logic [NUM_SLOTS-1:0] sel_in,
  input  logic [2:0]           func_in,
  input  logic [5:0]           dword_in,
  input  logic [3:0]           be_in,
  input  logic [31:0]          wdata_in,
  input  logic                 cfg_ack,
  input  logic [31:0]          cfg_rdata,
  output logic                 idle,
  output logic                 done,
  output logic [31:0]          rdata,
  output logic [NUM_SLOTS-1:0] cfg_sel,
  output logic [3:0]           cfg_cmd,
  output logic [2:0]           cfg_func,
  output logic [7:0]           cfg_reg,
  output logic [3:0]           cfg_be,
  output logic [31:0]          cfg_wdata
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  eng_st_t       st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          present_q;

  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      present_q <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      cfg_sel   <= '0;
      cfg_cmd   <= CMD_IDLE;
      cfg_func  <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st        <= ST_WAIT;
            cnt       <= '0;
            wr_q      <= is_wr;
            present_q <= present;
            cfg_sel   <= sel_in;
            cfg_cmd   <= present ? (is_wr ? CMD_CFG_WR : CMD_CFG_RD) : CMD_IDLE;
            cfg_func  <= func_in;
            cfg_reg   <= {dword_in, 2'b00};
            cfg_be    <= be_in;
            cfg_wdata <= wdata_in;
          end
        end
        ST_WAIT: begin
          if (present_q && cfg_ack) begin
            st      <= ST_IDLE;
            done    <= 1'b1;
            rdata   <= wr_q ? '1 : cfg_rdata;
            cfg_sel <= '0;
            cfg_cmd <= CMD_IDLE;
          end else if (cnt == LAST) begin
            st      <= ST_IDLE;
            done    <= 1'b1;
            rdata   <= '1;
            cfg_sel <= '0;
            cfg_cmd <= CMD_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int          NUM_SLOTS = 8,
  parameter int          TIMEOUT   = 8,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          io_addr,
  input  logic [3:0]           io_be,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [31:0]          io_wdata,
  output logic [31:0]          io_rdata,
  output logic                 io_ack,
  output logic                 io_pass,
  output logic [NUM_SLOTS-1:0] cfg_sel,
  output logic [3:0]           cfg_cmd,
  output logic [2:0]           cfg_func,
  output logic [7:0]           cfg_reg,
  output logic [3:0]           cfg_be,
  output logic [31:0]          cfg_wdata,
  input  logic [31:0]          cfg_rdata,
  input  logic                 cfg_ack
);
  tgt_addr_t             tgt;
  logic [31:0]           tgt_word;
  logic                  eng_idle, eng_done;
  logic [31:0]           eng_rdata;
  logic                  present;
  logic [NUM_SLOTS-1:0]  sel_dec;

  logic strobe, accept, win_addr, win_data, addr_full;
  logic ld_addr, rd_addr, start, pass;
  logic addr_ack_q, pass_q;
  logic [31:0] addr_rdata_q;
  logic unused_low;

  assign unused_low = ^{io_addr[1:0], ADDR_PORT[1:0], DATA_PORT[1:0]};

  assign strobe    = io_wr | io_rd;
  assign accept    = strobe && eng_idle;
  assign win_addr  = (io_addr[15:2] == ADDR_PORT[15:2]);
  assign win_data  = (io_addr[15:2] == DATA_PORT[15:2]);
  assign addr_full = win_addr && (io_be == 4'hF);
  assign ld_addr   = accept && io_wr && addr_full;
  assign rd_addr   = accept && !io_wr && addr_full;
  assign start     = accept && win_data && tgt.en;
  assign pass      = accept && !addr_full && !(win_data && tgt.en);

  cfgb_addr_reg u_areg (
    .clk     (clk),
    .rst     (rst),
    .load    (ld_addr),
    .wdata   (io_wdata),
    .tgt     (tgt),
    .rd_word (tgt_word)
  );

  cfgb_slot_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .bus     (tgt.bus),
    .dev     (tgt.dev),
    .present (present),
    .onehot  (sel_dec)
  );

  cfgb_cycle_eng #(.NUM_SLOTS(NUM_SLOTS), .TIMEOUT(TIMEOUT)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_wr     (io_wr),
    .present   (present),
    .sel_in    (sel_dec),
    .func_in   (tgt.func),
    .dword_in  (tgt.dword),
    .be_in     (io_be),
    .wdata_in  (io_wdata),
    .cfg_ack   (cfg_ack),
    .cfg_rdata (cfg_rdata),
    .idle      (eng_idle),
    .done      (eng_done),
    .rdata     (eng_rdata),
    .cfg_sel   (cfg_sel),
    .cfg_cmd   (cfg_cmd),
    .cfg_func  (cfg_func),
    .cfg_reg   (cfg_reg),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_ack_q   <= 1'b0;
      pass_q       <= 1'b0;
      addr_rdata_q <= '0;
    end else begin
      addr_ack_q   <= ld_addr | rd_addr;
      pass_q       <= pass;
      addr_rdata_q <= rd_addr ? tgt_word : '0;
    end
  end

  assign io_ack   = addr_ack_q | eng_done;
  assign io_pass  = pass_q;
  assign io_rdata = addr_ack_q ? addr_rdata_q : eng_rdata;
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker
  import cfgb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int TIMEOUT   = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 io_ack,
  input logic                 io_pass,
  input logic [NUM_SLOTS-1:0] cfg_sel,
  input logic [3:0]           cfg_cmd
);
  localparam int CW = $clog2(TIMEOUT + 2);
  logic [CW-1:0] busy_cnt;
  logic          busy;

  assign busy = |cfg_sel;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cfg_sel)); // R5
  AST_SEL_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
    (|cfg_sel) |-> (cfg_cmd == CMD_CFG_RD || cfg_cmd == CMD_CFG_WR)); // R5
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((|cfg_sel) && (|$past(cfg_sel))) |-> $stable(cfg_sel)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    io_ack |-> (cfg_sel == '0 && cfg_cmd == CMD_IDLE)); // R6
  AST_SEL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(busy_cnt) < TIMEOUT)); // R7
  AST_ACK_PASS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(io_ack && io_pass)); // R3
  AST_PASS_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    io_pass |-> (cfg_sel == '0)); // R4
endmodule

bind cfg_port_bridge cfgb_checker #(.NUM_SLOTS(NUM_SLOTS), .TIMEOUT(TIMEOUT)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .io_ack  (io_ack),
  .io_pass (io_pass),
  .cfg_sel (cfg_sel),
  .cfg_cmd (cfg_cmd)
);

// File: tb/cfg_port_bridge_tb_top.sv
module cfg_port_bridge_tb_top;
  localparam int NSL = 8;
  localparam int TMO = 8;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [3:0]  dly;
    logic [31:0] resp;
    logic        pass;
    logic [3:0]  lat;
    logic [31:0] rdata;
    logic [7:0]  sel;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0CF8, 4'hF, 32'h80001D10, 4'hF, 32'h0,        1'b0, 4'd0, 32'h0,        8'h00, 4'd2}, // R2
    '{1'b0, 16'h0CF8, 4'hF, 32'h0,        4'hF, 32'h0,        1'b0, 4'd0, 32'h80001D10, 8'h00, 4'd2}, // R2
    '{1'b1, 16'h0CF8, 4'hF, 32'hFF001D13, 4'hF, 32'h0,        1'b0, 4'd0, 32'h0,        8'h00, 4'd2}, // R2
    '{1'b0, 16'h0CF8, 4'hF, 32'h0,        4'hF, 32'h0,        1'b0, 4'd0, 32'h80001D10, 8'h00, 4'd2}, // R2
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,        4'h0, 32'h12345678, 1'b0, 4'd1, 32'h12345678, 8'h08, 4'd6}, // R6
    '{1'b1, 16'h0CFC, 4'h3, 32'hCAFE0001, 4'h2, 32'h0,        1'b0, 4'd3, 32'h0,        8'h08, 4'd5}, // R5
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,        4'hF, 32'h0,        1'b0, 4'd8, 32'hFFFFFFFF, 8'h08, 4'd7}, // R7
    '{1'b1, 16'h0CF8, 4'h3, 32'h0,        4'hF, 32'h0,        1'b1, 4'd0, 32'h0,        8'h00, 4'd3}, // R3
    '{1'b0, 16'h0CF8, 4'hF, 32'h0,        4'hF, 32'h0,        1'b0, 4'd0, 32'h80001D10, 8'h00, 4'd3}, // R3
    '{1'b1, 16'h0080, 4'hF, 32'h00001234, 4'hF, 32'h0,        1'b1, 4'd0, 32'h0,        8'h00, 4'd3}, // R3
    '{1'b1, 16'h0CF8, 4'hF, 32'h00001D10, 4'hF, 32'h0,        1'b0, 4'd0, 32'h0,        8'h00, 4'd4}, // R4
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,        4'h0, 32'h00000055, 1'b1, 4'd0, 32'h0,        8'h00, 4'd4}, // R4
    '{1'b1, 16'h0CF8, 4'hF, 32'h80005000, 4'hF, 32'h0,        1'b0, 4'd0, 32'h0,        8'h00, 4'd8}, // R8
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,        4'h1, 32'hAAAA5555, 1'b0, 4'd8, 32'hFFFFFFFF, 8'h00, 4'd8}, // R8
    '{1'b1, 16'h0CF8, 4'hF, 32'h80010800, 4'hF, 32'h0,        1'b0, 4'd0, 32'h0,        8'h00, 4'd8}, // R8
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,        4'h0, 32'h11112222, 1'b0, 4'd8, 32'hFFFFFFFF, 8'h00, 4'd8}, // R8
    '{1'b1, 16'h0CF8, 4'hF, 32'h80003FFC, 4'hF, 32'h0,        1'b0, 4'd0, 32'h0,        8'h00, 4'd5}, // R5
    '{1'b0, 16'h0CFF, 4'h8, 32'h0,        4'h7, 32'h0BADF00D, 1'b0, 4'd8, 32'h0BADF00D, 8'h80, 4'd6}, // R6
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,        4'h8, 32'h77777777, 1'b0, 4'd8, 32'hFFFFFFFF, 8'h80, 4'd7}  // R7
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [15:0]    io_addr = '0;
  logic [3:0]     io_be = '0;
  logic           io_wr = 1'b0;
  logic           io_rd = 1'b0;
  logic [31:0]    io_wdata = '0;
  logic [31:0]    io_rdata;
  logic           io_ack, io_pass;
  logic [NSL-1:0] cfg_sel;
  logic [3:0]     cfg_cmd;
  logic [2:0]     cfg_func;
  logic [7:0]     cfg_reg;
  logic [3:0]     cfg_be;
  logic [31:0]    cfg_wdata;
  logic [31:0]    cfg_rdata = '0;
  logic           cfg_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] shadow = '0;

  always #4 clk = ~clk;

  cfg_port_bridge #(.NUM_SLOTS(NSL), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .io_pass(io_pass), .cfg_sel(cfg_sel), .cfg_cmd(cfg_cmd), .cfg_func(cfg_func),
    .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack)
  );

  task automatic chk(input logic ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_vec(input vec_t v);
    logic got_ack, got_pass;
    int lat;
    logic [31:0] rd;
    logic [NSL-1:0] s_sel;
    logic [3:0] s_cmd, s_be;
    logic [2:0] s_func;
    logic [7:0] s_reg;
    logic [31:0] s_wd;
    int req;
    req = int'(v.req);
    got_ack = 0; got_pass = 0; lat = 99; rd = '0;
    s_sel = '0; s_cmd = '0; s_be = '0; s_func = '0; s_reg = '0; s_wd = '0;
    @(negedge clk);
    io_addr = v.addr; io_be = v.be; io_wdata = v.wdata;
    io_wr = v.wr; io_rd = !v.wr; cfg_rdata = v.resp;
    @(posedge clk);
    @(negedge clk);
    io_wr = 0; io_rd = 0;
    for (int k = 0; k < 20; k++) begin
      if (io_ack || io_pass) begin
        got_ack = io_ack; got_pass = io_pass; lat = k; rd = io_rdata;
        break;
      end
      if (cfg_sel != '0 && s_sel == '0) begin
        s_sel = cfg_sel; s_cmd = cfg_cmd; s_be = cfg_be;
        s_func = cfg_func; s_reg = cfg_reg; s_wd = cfg_wdata;
      end
      cfg_ack = (v.dly != 4'hF) && (k == int'(v.dly));
      @(negedge clk);
    end
    cfg_ack = 0;
    chk(got_pass == v.pass && got_ack == !v.pass, req, "ack/pass kind",
        {30'b0, got_ack, got_pass}, {30'b0, !v.pass, v.pass});
    chk(lat == int'(v.lat), req, "completion latency", 32'(lat), 32'(v.lat));
    if (!v.wr && !v.pass)
      chk(rd == v.rdata, req, "read data", rd, v.rdata);
    chk(s_sel == v.sel, req, "slot select", 32'(s_sel), 32'(v.sel));
    if (v.sel != '0) begin
      chk(s_cmd == (v.wr ? 4'hB : 4'hA), 5, "command code", 32'(s_cmd), v.wr ? 32'hB : 32'hA); // R5
      chk(s_reg == {shadow[7:2], 2'b00}, 5, "register offset", 32'(s_reg), {24'b0, shadow[7:2], 2'b00});
      chk(s_func == shadow[10:8], 5, "function", 32'(s_func), 32'(shadow[10:8]));
      chk(s_be == v.be, 5, "byte lanes", 32'(s_be), 32'(v.be));
      if (v.wr) chk(s_wd == v.wdata, 5, "write data", s_wd, v.wdata);
    end
    if (v.wr && v.addr[15:2] == 14'h033E && v.be == 4'hF && !v.pass)
      shadow = v.wdata & 32'h80FFFFFC;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL R0 watchdog expired: actual %h expected %h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    chk(cfg_sel == '0, 1, "select after reset", 32'(cfg_sel), 32'h0);
    chk(cfg_cmd == 4'h0, 1, "command after reset", 32'(cfg_cmd), 32'h0);
    chk(!io_ack && !io_pass, 1, "ack/pass after reset", {30'b0, io_ack, io_pass}, 32'h0);
    run_vec('{1'b0, 16'h0CF8, 4'hF, 32'h0, 4'hF, 32'h0, 1'b0, 4'd0, 32'h0, 8'h00, 4'd1}); // R1
    run_vec('{1'b0, 16'h0CFC, 4'hF, 32'h0, 4'h0, 32'h1, 1'b1, 4'd0, 32'h0, 8'h00, 4'd1}); // R1

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: strobe during a running cycle is ignored
    run_vec('{1'b1, 16'h0CF8, 4'hF, 32'h80001D10, 4'hF, 32'h0, 1'b0, 4'd0, 32'h0, 8'h00, 4'd9});
    @(negedge clk);
    io_addr = 16'h0CFC; io_be = 4'hF; io_rd = 1;
    @(posedge clk); @(negedge clk);
    io_rd = 0;
    @(negedge clk);
    io_addr = 16'h0CF8; io_wdata = 32'h80000000; io_wr = 1;
    @(posedge clk); @(negedge clk);
    io_wr = 0;
    chk(!io_ack && !io_pass, 9, "strobe while busy answered", {30'b0, io_ack, io_pass}, 32'h0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      if (io_ack) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen && io_rdata == 32'hFFFFFFFF, 9, "busy cycle timeout data", io_rdata, 32'hFFFFFFFF);
    run_vec('{1'b0, 16'h0CF8, 4'hF, 32'h0, 4'hF, 32'h0, 1'b0, 4'd0, 32'h80001D10, 8'h00, 4'd9}); // R9

    // R1: reset in the middle of a cycle
    @(negedge clk);
    io_addr = 16'h0CFC; io_be = 4'hF; io_rd = 1;
    @(posedge clk); @(negedge clk);
    io_rd = 0;
    chk(cfg_sel == 8'h08, 1, "select before mid reset", 32'(cfg_sel), 32'h08);
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    chk(cfg_sel == '0 && cfg_cmd == 4'h0, 1, "select/cmd after mid reset",
        {20'b0, cfg_sel, cfg_cmd}, 32'h0);
    chk(!io_ack && !io_pass, 1, "ack/pass after mid reset", {30'b0, io_ack, io_pass}, 32'h0);
    shadow = '0;
    run_vec('{1'b0, 16'h0CF8, 4'hF, 32'h0, 4'hF, 32'h0, 1'b0, 4'd0, 32'h0, 8'h00, 4'd1}); // R1

    finish_run();
  end
endmodule